// File: doc/BRIEF.md
# Quadrature Encoder Period-per-Edge-Group Meter

This block measures shaft speed from a two-phase quadrature encoder. Phase A and phase B are resynchronised to the system clock, and their transitions become velocity events. In half-resolution mode only phase A transitions count. In full-resolution mode transitions on either phase count. A postscaler passes one pulse for every N events. Each postscaled pulse copies a free-running time-base counter into the velocity register and restarts the counter from zero. The captured value therefore gives the elapsed time for one group of N encoder edges.

Software or a control loop reads the velocity register each time the capture strobe fires. At high speed, a large divide ratio keeps the count resolution useful. At low speed, a small ratio keeps the update rate up. If no capture arrives before the time base fills, the count saturates and a sticky overflow flag reports that the speed is below the measurable range.

Top module: `enc_speed_meter`

## Requirements
- R1: With `x4_mode_i` = 0, each rising or falling transition of phase A is one velocity event, and phase B transitions produce no event.
- R2: With `x4_mode_i` = 1, each transition of phase A or phase B is one velocity event. Transitions on both phases in the same cycle count as a single event.
- R3: Phase inputs pass through a two-stage synchronizer before edge detection. A phase change sampled at a rising edge raises `cap_stb_o` after the third rising edge, counting the sampling edge, when the divide ratio is 1.
- R4: `div_sel_i` selects the postscaler ratio: 0 gives 1, 1 gives 4, 2 gives 16 and 3 gives 64 events per capture.
- R5: A capture copies the time base into `vel_q_o` and clears the time base to zero. The time base then adds one per clock, so a steady capture period of P cycles gives a captured value of P-1.
- R6: `cap_stb_o` is high for exactly the one cycle in which `vel_q_o` takes a new captured value. `vel_q_o` holds its value at all other times.
- R7: When the time base reaches all ones without a capture, it stays there and `ovf_o` is set and remains set. The next capture stores all ones into `vel_q_o` and clears `ovf_o`.
- R8: Measurement is enabled while `vel_en_ni` is 0. While it is 1, no event is counted and no capture occurs. During that time the time base, the postscaler count and `ovf_o` are held at zero.
- R9: Any change of `div_sel_i` clears the postscaler's partial event count.
- R10: After reset, `vel_q_o` = 0, `cap_stb_o` = 0 and `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_a_i | input | 1 | Encoder phase A, asynchronous |
| phase_b_i | input | 1 | Encoder phase B, asynchronous |
| x4_mode_i | input | 1 | 0: phase A edges only, 1: edges of both phases |
| div_sel_i | input | 2 | Postscaler ratio select (1, 4, 16, 64) |
| vel_en_ni | input | 1 | Measurement enable, active low |
| vel_q_o | output | 16 | Captured time base (velocity register) |
| cap_stb_o | output | 1 | One-cycle strobe on each capture |
| ovf_o | output | 1 | Sticky time-base saturation flag |

## Verification
The main function is driven with a steady quadrature sequence. The vectors cover every divide ratio, both resolution modes and several edge spacings. The steady captured value separates the two modes, because half-resolution doubles the period per event, and it separates the four ratios by their multiplier. Directed patterns cover the remaining behaviours. Single toggles show the synchronizer latency. A long idle stretch shows saturation. Partial event groups interrupted by a ratio change or a disable pulse show whether the postscaler count was discarded. Toggling while disabled shows that no capture takes place.

// File: rtl/encv_pkg.sv
package encv_pkg;

   typedef enum logic {
      EV_HALF = 1'b0,
      EV_FULL = 1'b1
   } ev_mode_e;

endpackage

// File: rtl/enc_edge_event.sv
module enc_edge_event #(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ph_a_i,
   input  logic              ph_b_i,
   input  encv_pkg::ev_mode_e mode_i,
   input  logic              gate_i,
   output logic              ev_o
);
   import encv_pkg::*;

   localparam int TOP = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [TOP:0] sync_a, sync_b;
   logic         dly_a, dly_b;
   logic         edge_a, edge_b;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_a <= '0;
         sync_b <= '0;
         dly_a  <= 1'b0;
         dly_b  <= 1'b0;
      end else begin
         sync_a <= {sync_a[TOP-1:0], ph_a_i};
         sync_b <= {sync_b[TOP-1:0], ph_b_i};
         dly_a  <= sync_a[TOP];
         dly_b  <= sync_b[TOP];
      end
   end

   assign edge_a = sync_a[TOP] ^ dly_a;
   assign edge_b = sync_b[TOP] ^ dly_b;

   always_comb begin
      ev_o = 1'b0;
      if (gate_i) begin
         if (mode_i == EV_FULL) ev_o = edge_a | edge_b;
         else                   ev_o = edge_a;
      end
   end

   // R1: half-resolution mode ignores phase B alone
   p_half_ignores_b_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == EV_HALF && edge_b && !edge_a) |-> !ev_o);

   // R8: no event while disabled
   p_no_event_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gate_i |-> !ev_o);

endmodule

// File: rtl/enc_event_div.sv
module enc_event_div #(
   parameter int STEP_LOG = 2,
   parameter int SEL_W    = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             gate_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             ev_i,
   output logic             pulse_o
);
   localparam int NSEL  = 1 << SEL_W;
   localparam int CNT_W = STEP_LOG * (NSEL - 1);

   generate
      if (STEP_LOG < 1 || CNT_W > 24) begin : g_bad_div
         $error("postscaler range out of bounds");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic [CNT_W:0]   lim_w;
   logic [SEL_W-1:0] sel_q;
   logic             clr;

   always_comb begin
      lim_w = ({{CNT_W{1'b0}}, 1'b1} << (STEP_LOG * int'(sel_i))) - 1'b1;
      limit = lim_w[CNT_W-1:0];
   end

   assign clr     = !gate_i || (sel_i != sel_q);
   assign pulse_o = ev_i && !clr && (cnt_q == limit);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         sel_q <= '0;
      end else begin
         sel_q <= sel_i;
         if (clr)              cnt_q <= '0;
         else if (ev_i) begin
            if (cnt_q == limit) cnt_q <= '0;
            else                cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R4: a postscaled pulse always stems from an event
   p_pulse_needs_event_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o |-> ev_i);

   // R9: a ratio change discards the partial count
   p_sel_change_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i != sel_q) |=> (cnt_q == '0));

endmodule

// File: rtl/enc_period_timer.sv
module enc_period_timer #(
   parameter int TB_W = 16
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            gate_i,
   input  logic            cap_i,
   output logic [TB_W-1:0] val_o,
   output logic            stb_o,
   output logic            ovf_o
);
   localparam logic [TB_W-1:0] TB_MAX = '1;

   generate
      if (TB_W < 2) begin : g_bad_tb
         $error("TB_W must be at least 2");
      end
   endgenerate

   logic [TB_W-1:0] tb_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tb_q  <= '0;
         val_o <= '0;
         stb_o <= 1'b0;
         ovf_o <= 1'b0;
      end else begin
         stb_o <= 1'b0;
         if (!gate_i) begin
            tb_q  <= '0;
            ovf_o <= 1'b0;
         end else if (cap_i) begin
            val_o <= tb_q;
            tb_q  <= '0;
            stb_o <= 1'b1;
            ovf_o <= 1'b0;
         end else if (tb_q == TB_MAX) begin
            ovf_o <= 1'b1;
         end else begin
            tb_q <= tb_q + 1'b1;
         end
      end
   end

   // R5: capture restarts the time base from zero
   p_clear_on_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_i && cap_i) |=> (tb_q == '0));

   // R7: saturation holds the count
   p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_i && !cap_i && tb_q == TB_MAX) |=> (tb_q == TB_MAX && ovf_o));

   // R6: register changes only together with the strobe
   p_val_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stb_o |-> $stable(val_o) || $past(!rst_ni));

   // R8: disabled means no strobe and cleared flag
   p_disabled_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gate_i |=> (!stb_o && !ovf_o));

endmodule

// File: rtl/enc_speed_meter.sv
module enc_speed_meter #(
   parameter int TB_W        = 16,
   parameter int SYNC_STAGES = 2,
   parameter int STEP_LOG    = 2,
   parameter int SEL_W       = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             phase_a_i,
   input  logic             phase_b_i,
   input  logic             x4_mode_i,
   input  logic [SEL_W-1:0] div_sel_i,
   input  logic             vel_en_ni,
   output logic [TB_W-1:0]  vel_q_o,
   output logic             cap_stb_o,
   output logic             ovf_o
);
   import encv_pkg::*;

   logic     gate;
   logic     ev;
   logic     cap;
   ev_mode_e mode;

   assign gate = !vel_en_ni;
   assign mode = ev_mode_e'(x4_mode_i);

   enc_edge_event #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ph_a_i (phase_a_i),
      .ph_b_i (phase_b_i),
      .mode_i (mode),
      .gate_i (gate),
      .ev_o   (ev)
   );

   enc_event_div #(.STEP_LOG(STEP_LOG), .SEL_W(SEL_W)) div_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .gate_i  (gate),
      .sel_i   (div_sel_i),
      .ev_i    (ev),
      .pulse_o (cap)
   );

   enc_period_timer #(.TB_W(TB_W)) tmr_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .gate_i (gate),
      .cap_i  (cap),
      .val_o  (vel_q_o),
      .stb_o  (cap_stb_o),
      .ovf_o  (ovf_o)
   );

   // R6: strobe follows a capture request by one cycle
   p_stb_follows_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_stb_o |-> $past(cap));

endmodule

// File: tb/enc_speed_meter_tb.sv
`timescale 1ns/1ps
module enc_speed_meter_tb_top;

   typedef struct packed {
      logic        x4;
      logic [1:0]  sel;
      logic [7:0]  gap;
      logic [15:0] exp;
   } vec_t;

   // expected = ratio * (gap * (x4 ? 1 : 2)) - 1   (R1, R2, R4, R5)
   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 2'd0, 8'd5, 16'd9},
      '{1'b1, 2'd0, 8'd5, 16'd4},
      '{1'b1, 2'd1, 8'd3, 16'd11},
      '{1'b0, 2'd1, 8'd3, 16'd23},
      '{1'b1, 2'd2, 8'd2, 16'd31},
      '{1'b0, 2'd2, 8'd7, 16'd223},
      '{1'b1, 2'd3, 8'd1, 16'd63},
      '{1'b0, 2'd3, 8'd4, 16'd511}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ph_a = 1'b0, ph_b = 1'b0;
   logic        x4 = 1'b0;
   logic [1:0]  sel = 2'd0;
   logic        en_n = 1'b1;
   logic [15:0] vel_q;
   logic        stb, ovf;

   int          total = 0, bad = 0;
   int          stb_cnt = 0;
   logic [15:0] last_val = '0;
   logic        next_is_a = 1'b1;

   always #2 clk = ~clk;

   enc_speed_meter dut_i (
      .clk_i(clk), .rst_ni(rst_n), .phase_a_i(ph_a), .phase_b_i(ph_b),
      .x4_mode_i(x4), .div_sel_i(sel), .vel_en_ni(en_n),
      .vel_q_o(vel_q), .cap_stb_o(stb), .ovf_o(ovf)
   );

   always @(negedge clk) begin
      if (stb) begin
         stb_cnt  <= stb_cnt + 1;
         last_val <= vel_q;
      end
   end

   task automatic chk(input logic ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // quadrature step: alternate A and B
   task automatic step(input int gap);
      @(negedge clk);
      if (next_is_a) ph_a = ~ph_a;
      else           ph_b = ~ph_b;
      next_is_a = ~next_is_a;
      repeat (gap - 1) @(negedge clk);
   endtask

   task automatic setup(input logic m, input logic [1:0] s);
      @(negedge clk);
      en_n = 1'b1;
      wait_n(3);
      x4 = m; sel = s;
      wait_n(2);
      en_n = 1'b0;
      wait_n(5);
      stb_cnt = 0;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      logic [15:0] hold;
      wait_n(3);
      // R10: reset state
      chk(vel_q == 16'd0, "R10 vel", vel_q, 0);
      chk(stb == 1'b0, "R10 stb", stb, 0);
      chk(ovf == 1'b0, "R10 ovf", ovf, 0);
      @(negedge clk); rst_n = 1'b1;
      wait_n(2);

      // vector table: modes, ratios, spacings
      for (int v = 0; v < NVEC; v++) begin
         int n_ev;
         int steps;
         setup(VECS[v].x4, VECS[v].sel);
         n_ev  = 1 << (2 * int'(VECS[v].sel));
         steps = VECS[v].x4 ? (3 * n_ev + 4) : (6 * n_ev + 4);
         for (int i = 0; i < steps; i++) step(int'(VECS[v].gap));
         wait_n(6);
         chk(stb_cnt >= 2, "R4 capture count", stb_cnt, 2);
         chk(last_val == VECS[v].exp, VECS[v].x4 ? "R2/R5 value" : "R1/R5 value",
             last_val, VECS[v].exp);
      end

      // R3 latency and R6 single-cycle strobe
      setup(1'b0, 2'd0);
      next_is_a = 1'b1;
      @(negedge clk); ph_a = ~ph_a;
      @(negedge clk); chk(stb == 1'b0, "R3 edge1", stb, 0);
      @(negedge clk); chk(stb == 1'b0, "R3 edge2", stb, 0);
      @(negedge clk); chk(stb == 1'b1, "R3 edge3", stb, 1);
      @(negedge clk); chk(stb == 1'b0, "R6 one cycle", stb, 0);
      hold = vel_q;
      wait_n(20);
      chk(vel_q == hold, "R6 hold", vel_q, hold);

      // R1: phase B alone in half mode gives nothing
      stb_cnt = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); ph_b = ~ph_b; wait_n(3);
      end
      wait_n(4);
      chk(stb_cnt == 0, "R1 B ignored", stb_cnt, 0);

      // R9: ratio change discards partial count (ratio 4, full mode)
      setup(1'b1, 2'd1);
      next_is_a = 1'b1;
      for (int i = 0; i < 3; i++) step(3);
      sel = 2'd2; wait_n(3);
      sel = 2'd1; wait_n(3);
      step(3); wait_n(6);
      chk(stb_cnt == 0, "R9 cleared", stb_cnt, 0);
      for (int i = 0; i < 3; i++) step(3);
      wait_n(6);
      chk(stb_cnt == 1, "R9 fresh group", stb_cnt, 1);

      // R8: disable pulse discards partial count
      setup(1'b1, 2'd1);
      for (int i = 0; i < 3; i++) step(3);
      en_n = 1'b1; wait_n(3); en_n = 1'b0; wait_n(3);
      step(3); wait_n(6);
      chk(stb_cnt == 0, "R8 divider cleared", stb_cnt, 0);

      // R8: toggles while disabled give no capture
      en_n = 1'b1; wait_n(2);
      hold = vel_q; stb_cnt = 0;
      for (int i = 0; i < 20; i++) step(2);
      wait_n(6);
      chk(stb_cnt == 0, "R8 no capture", stb_cnt, 0);
      chk(vel_q == hold, "R8 vel hold", vel_q, hold);

      // R7: saturation, flag, capture of all ones
      setup(1'b0, 2'd0);
      wait_n(65600);
      chk(ovf == 1'b1, "R7 ovf set", ovf, 1);
      @(negedge clk); ph_a = ~ph_a;
      wait_n(5);
      chk(stb_cnt == 1, "R7 capture", stb_cnt, 1);
      chk(last_val == 16'hFFFF, "R7 value", last_val, 16'hFFFF);
      chk(ovf == 1'b0, "R7 ovf cleared", ovf, 0);

      // R8: disable clears the flag
      wait_n(65600);
      chk(ovf == 1'b1, "R7 ovf set again", ovf, 1);
      en_n = 1'b1; wait_n(2);
      chk(ovf == 1'b0, "R8 ovf cleared", ovf, 0);

      finish_run();
   end

endmodule